// File: doc/BRIEF.md
# Serial Clock Duty-Cycle Generator

This block makes the serial clock for a SPI master out of the system clock. A power-of-two prescaler turns the system clock into a slower tick. Two counters then set how many ticks the serial clock spends low and how many it spends high. Because the two counts are separate, the duty cycle can be set as well as the frequency. When all three fields are zero, the block bypasses the counters and the serial clock toggles on every system clock cycle.

The shifter asks for clocking by holding `run` high. Each period begins with the low phase and ends with the high phase. The block samples the fields only when a period begins, so a field change never cuts short a phase that is already running. On every transition of the serial clock the block emits a one-cycle strobe, and the shifter uses these strobes to launch and capture bits.

The block checks the fields for illegal combinations and reports them on an error flag. While the fields are illegal, the serial clock stays low. In the bypass mode the downstream shifter cannot use characters of 2 or 10 bits; that restriction is the shifter's to enforce.

Top module: `sck_duty_gen`

## Requirements
- R1: After reset, `sck_o`, `rise_o`, `fall_o` and `cfg_err_o` are all 0.
- R2: Let s be `scale_i` (0..8) and L be `lo_i` (1..15). Each low phase lasts L·2^s system clock cycles. After `run` is sampled high from idle, the first rising edge comes only after one full low phase.
- R3: With `hi_i` = H (1..15), each high phase lasts H·2^s system clock cycles.
- R4: When `scale_i`, `hi_i` and `lo_i` are all zero, `sck_o` toggles every cycle: 1 cycle low, then 1 cycle high.
- R5: The fields are illegal when `scale_i` > 8, or when some count is zero but the three fields are not all zero. One cycle after an illegal setting is applied, `cfg_err_o` is 1. While the setting stays illegal, no period starts and `sck_o` stays 0.
- R6: `rise_o` is 1 for exactly the first cycle in which `sck_o` is 1 after being 0. `fall_o` is 1 for exactly the first cycle in which `sck_o` is 0 after being 1. The two strobes are never 1 together.
- R7: A change to `scale_i`, `hi_i` or `lo_i` made during a period does not alter that period. It is applied from the next low phase onwards.
- R8: When `run` drops, the current period runs to the end of its high phase. `sck_o` then returns to 0 and stays there.
- R9: When `en` is 0, `sck_o` is 0 from the next cycle onwards and no period runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Block enable; 0 forces the idle state |
| run | input | 1 | Clocking request from the shifter |
| scale_i | input | 4 | Prescaler exponent, legal 0..8 |
| hi_i | input | 4 | High-phase length in ticks |
| lo_i | input | 4 | Low-phase length in ticks |
| sck_o | output | 1 | Serial clock, idles low |
| rise_o | output | 1 | One-cycle strobe on a rising edge of sck_o |
| fall_o | output | 1 | One-cycle strobe on a falling edge of sck_o |
| cfg_err_o | output | 1 | Registered flag for illegal field values |

## Verification
The bench uses the default parameters: a 4-bit scale, 4-bit counts and a largest legal scale of 8. Because these fields are small, a near-complete sweep is possible. The sweep covers scales 0 to 3 with every high and low count from 1 to 3, and checks each phase length against count·2^scale. Separate cases cover the widest scale, the bypass mode, every kind of illegal field, a field change in the middle of a period, dropping `run`, and dropping the enable.

// File: rtl/sck_pkg.sv
package sck_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } phase_e;
endpackage

// File: rtl/sck_cfg_check.sv
module sck_cfg_check #(
  parameter int SCALE_W   = 4,
  parameter int CNT_W     = 4,
  parameter int SCALE_MAX = 8
) (
  input  logic [SCALE_W-1:0] scale,
  input  logic [CNT_W-1:0]   hi,
  input  logic [CNT_W-1:0]   lo,
  output logic               illegal,
  output logic [CNT_W-1:0]   eff_hi,
  output logic [CNT_W-1:0]   eff_lo
);
  logic direct;
  logic over;
  logic zero_cnt;

  always_comb begin
    direct   = (scale == '0) && (hi == '0) && (lo == '0);
    over     = (int'(scale) > SCALE_MAX);
    zero_cnt = (hi == '0) || (lo == '0);
    illegal  = over || (zero_cnt && !direct);
    eff_hi   = direct ? CNT_W'(1) : hi;
    eff_lo   = direct ? CNT_W'(1) : lo;
  end
endmodule

// File: rtl/sck_prescaler.sv
module sck_prescaler #(
  parameter int SCALE_W = 4,
  parameter int PRE_W   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic [SCALE_W-1:0] scale,
  output logic               tick
);
  logic [PRE_W-1:0] pcnt;
  logic [PRE_W-1:0] mask;

  for (genvar g = 0; g < PRE_W; g++) begin : g_mask
    assign mask[g] = (int'(scale) > g);
  end

  assign tick = !clear && (pcnt == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pcnt <= '0;
    else if (clear)  pcnt <= '0;
    else if (tick)   pcnt <= '0;
    else             pcnt <= pcnt + PRE_W'(1);
  end
endmodule

// File: rtl/sck_phase_ctrl.sv
module sck_phase_ctrl
  import sck_pkg::*;
#(
  parameter int SCALE_W = 4,
  parameter int CNT_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               run,
  input  logic               illegal,
  input  logic [SCALE_W-1:0] scale_in,
  input  logic [CNT_W-1:0]   eff_hi,
  input  logic [CNT_W-1:0]   eff_lo,
  input  logic               tick,
  output logic               sck,
  output logic               rise,
  output logic               fall,
  output logic               presc_clear,
  output logic [SCALE_W-1:0] scale_q,
  output logic [CNT_W-1:0]   hi_q,
  output logic [CNT_W-1:0]   lo_q
);
  phase_e           phase;
  logic [CNT_W-1:0] cnt;
  logic             start_ok;
  logic             last;

  assign start_ok    = en && run && !illegal;
  assign last        = tick && (cnt == CNT_W'(1));
  assign presc_clear = (phase == PH_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      cnt     <= '0;
      sck     <= 1'b0;
      rise    <= 1'b0;
      fall    <= 1'b0;
      scale_q <= '0;
      hi_q    <= '0;
      lo_q    <= '0;
    end else begin
      rise <= 1'b0;
      fall <= 1'b0;
      if (!en) begin
        phase <= PH_IDLE;
        fall  <= sck;
        sck   <= 1'b0;
      end else begin
        unique case (phase)
          PH_IDLE: begin
            if (start_ok) begin
              scale_q <= scale_in;
              hi_q    <= eff_hi;
              lo_q    <= eff_lo;
              cnt     <= eff_lo;
              phase   <= PH_LOW;
            end
          end
          PH_LOW: begin
            if (last) begin
              phase <= PH_HIGH;
              cnt   <= hi_q;
              sck   <= 1'b1;
              rise  <= 1'b1;
            end else if (tick) begin
              cnt <= cnt - CNT_W'(1);
            end
          end
          PH_HIGH: begin
            if (last) begin
              sck  <= 1'b0;
              fall <= 1'b1;
              if (start_ok) begin
                scale_q <= scale_in;
                hi_q    <= eff_hi;
                lo_q    <= eff_lo;
                cnt     <= eff_lo;
                phase   <= PH_LOW;
              end else begin
                phase <= PH_IDLE;
              end
            end else if (tick) begin
              cnt <= cnt - CNT_W'(1);
            end
          end
          default: phase <= PH_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/sck_duty_gen.sv
module sck_duty_gen #(
  parameter int SCALE_W   = 4,
  parameter int CNT_W     = 4,
  parameter int SCALE_MAX = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               run,
  input  logic [SCALE_W-1:0] scale_i,
  input  logic [CNT_W-1:0]   hi_i,
  input  logic [CNT_W-1:0]   lo_i,
  output logic               sck_o,
  output logic               rise_o,
  output logic               fall_o,
  output logic               cfg_err_o
);
  localparam int PRE_W = (SCALE_MAX < 1) ? 1 : SCALE_MAX;

  logic               illegal;
  logic [CNT_W-1:0]   eff_hi;
  logic [CNT_W-1:0]   eff_lo;
  logic               tick;
  logic               presc_clear;
  logic [SCALE_W-1:0] scale_q;
  logic [CNT_W-1:0]   hi_q;
  logic [CNT_W-1:0]   lo_q;

  sck_cfg_check #(.SCALE_W(SCALE_W), .CNT_W(CNT_W), .SCALE_MAX(SCALE_MAX)) u_chk_cfg (
    .scale   (scale_i),
    .hi      (hi_i),
    .lo      (lo_i),
    .illegal (illegal),
    .eff_hi  (eff_hi),
    .eff_lo  (eff_lo)
  );

  sck_prescaler #(.SCALE_W(SCALE_W), .PRE_W(PRE_W)) u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (presc_clear),
    .scale (scale_q),
    .tick  (tick)
  );

  sck_phase_ctrl #(.SCALE_W(SCALE_W), .CNT_W(CNT_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .en          (en),
    .run         (run),
    .illegal     (illegal),
    .scale_in    (scale_i),
    .eff_hi      (eff_hi),
    .eff_lo      (eff_lo),
    .tick        (tick),
    .sck         (sck_o),
    .rise        (rise_o),
    .fall        (fall_o),
    .presc_clear (presc_clear),
    .scale_q     (scale_q),
    .hi_q        (hi_q),
    .lo_q        (lo_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_err_o <= 1'b0;
    else        cfg_err_o <= illegal;
  end
endmodule

// File: rtl/sck_duty_gen_chk.sv
module sck_duty_gen_chk #(
  parameter int SCALE_W   = 4,
  parameter int CNT_W     = 4,
  parameter int SCALE_MAX = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               en,
  input logic               sck_o,
  input logic               rise_o,
  input logic               fall_o,
  input logic               cfg_err_o,
  input logic [SCALE_W-1:0] scale_q,
  input logic [CNT_W-1:0]   hi_q,
  input logic [CNT_W-1:0]   lo_q
);
  AST_RISE_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |-> (sck_o && !$past(sck_o))) else $error("rise strobe off edge"); // R6
  AST_FALL_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |-> (!sck_o && $past(sck_o))) else $error("fall strobe off edge"); // R6
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise_o && fall_o)) else $error("both strobes"); // R6
  AST_EN_OFF_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !sck_o) else $error("sck high while disabled"); // R9
  AST_HIGH_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    sck_o |-> ($stable(scale_q) && $stable(hi_q) && $stable(lo_q))) else $error("config moved mid-period"); // R7
  AST_LATCHED_SCALE_OK: assert property (@(posedge clk) disable iff (!rst_n)
    sck_o |-> (int'(scale_q) <= SCALE_MAX)) else $error("illegal scale in use"); // R5
  AST_ERR_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_err_o && $past(cfg_err_o) && !sck_o) |=> !rise_o) else $error("start on illegal fields"); // R5
endmodule

bind sck_duty_gen sck_duty_gen_chk #(.SCALE_W(SCALE_W), .CNT_W(CNT_W), .SCALE_MAX(SCALE_MAX)) u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .en        (en),
  .sck_o     (sck_o),
  .rise_o    (rise_o),
  .fall_o    (fall_o),
  .cfg_err_o (cfg_err_o),
  .scale_q   (scale_q),
  .hi_q      (hi_q),
  .lo_q      (lo_q)
);

// File: tb/sck_duty_gen_test.sv
module sck_duty_gen_test;
  localparam int CLK_PERIOD = 10;
  localparam int CAP = 5000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic       run = 1'b0;
  logic [3:0] scale_i = '0;
  logic [3:0] hi_i = '0;
  logic [3:0] lo_i = '0;
  logic       sck_o, rise_o, fall_o, cfg_err_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sck_duty_gen uut (
    .clk(clk), .rst_n(rst_n), .en(en), .run(run),
    .scale_i(scale_i), .hi_i(hi_i), .lo_i(lo_i),
    .sck_o(sck_o), .rise_o(rise_o), .fall_o(fall_o), .cfg_err_o(cfg_err_o)
  );

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // counts samples at the current level; start = samples already counted
  task automatic run_len(bit lvl, int start, output int n);
    n = start;
    for (int i = 0; i < CAP; i++) begin
      @(negedge clk);
      if (sck_o != lvl) break;
      n++;
    end
  endtask

  task automatic stay_low(int cycles, string req);
    int highs = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (sck_o || rise_o) highs++;
    end
    chk(highs == 0, req, highs, 0);
  endtask

  // full sweep case: start, two periods, stop
  task automatic one_cfg(int s, int h, int l, int eh, int el);
    int n;
    @(negedge clk);
    scale_i = 4'(s); hi_i = 4'(h); lo_i = 4'(l); run = 1'b1;
    run_len(1'b0, 0, n);
    chk(n == el, $sformatf("R2 first low s=%0d h=%0d l=%0d", s, h, l), n, el);
    chk(rise_o == 1'b1, "R6 rise strobe", rise_o, 1);
    run_len(1'b1, 1, n);
    chk(n == eh, $sformatf("R3 high s=%0d h=%0d l=%0d", s, h, l), n, eh);
    chk(fall_o == 1'b1, "R6 fall strobe", fall_o, 1);
    run_len(1'b0, 1, n);
    chk(n == el, $sformatf("R2 second low s=%0d l=%0d", s, l), n, el);
    run = 1'b0;
    run_len(1'b1, 1, n);
    chk(n == eh, "R8 period completes after run drops", n, eh);
    stay_low(el + 3, "R8 idle after run drops");
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    chk(!sck_o && !rise_o && !fall_o && !cfg_err_o, "R1 reset state",
        {sck_o, rise_o, fall_o, cfg_err_o}, 0);
    rst_n = 1'b1;
    en = 1'b1;
    @(negedge clk);
    chk(!sck_o && !cfg_err_o, "R1 idle after reset", sck_o, 0);

    for (int s = 0; s <= 3; s++)
      for (int h = 1; h <= 3; h++)
        for (int l = 1; l <= 3; l++)
          one_cfg(s, h, l, h << s, l << s);

    one_cfg(8, 1, 2, 256, 512);
    one_cfg(2, 15, 1, 60, 4);

    // R4 bypass mode
    one_cfg(0, 0, 0, 1, 1);
    chk(cfg_err_o == 1'b0, "R4 bypass is legal", cfg_err_o, 0);

    // R5 illegal settings
    @(negedge clk);
    scale_i = 4'd9; hi_i = 4'd2; lo_i = 4'd2; run = 1'b1;
    @(negedge clk);
    chk(cfg_err_o == 1'b1, "R5 scale above 8 flagged", cfg_err_o, 1);
    stay_low(40, "R5 no start with scale above 8");
    scale_i = 4'd2; hi_i = 4'd0; lo_i = 4'd3;
    @(negedge clk);
    chk(cfg_err_o == 1'b1, "R5 zero high count flagged", cfg_err_o, 1);
    stay_low(40, "R5 no start with zero high count");
    scale_i = 4'd0; hi_i = 4'd3; lo_i = 4'd0;
    @(negedge clk);
    chk(cfg_err_o == 1'b1, "R5 lone zero low count flagged", cfg_err_o, 1);
    stay_low(20, "R5 no start with lone zero count");
    run = 1'b0;
    scale_i = 4'd1; hi_i = 4'd1; lo_i = 4'd1;
    @(negedge clk);
    chk(cfg_err_o == 1'b0, "R5 flag clears on legal fields", cfg_err_o, 0);

    // R7 change fields mid-period
    scale_i = 4'd1; hi_i = 4'd3; lo_i = 4'd2; run = 1'b1;
    run_len(1'b0, 0, n);
    chk(n == 4, "R7 first low", n, 4);
    hi_i = 4'd1; lo_i = 4'd3;
    run_len(1'b1, 1, n);
    chk(n == 6, "R7 high keeps old count", n, 6);
    run_len(1'b0, 1, n);
    chk(n == 6, "R7 next low uses new count", n, 6);
    run_len(1'b1, 1, n);
    chk(n == 2, "R7 next high uses new count", n, 2);

    // R9 enable drop while high
    for (int i = 0; i < CAP && !sck_o; i++) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    chk(sck_o == 1'b0, "R9 sck low after enable drop", sck_o, 0);
    chk(fall_o == 1'b1, "R9 fall strobe on enable drop", fall_o, 1);
    stay_low(20, "R9 stays idle while disabled");
    run = 1'b0;

    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 150000 && !done; i++) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    end
    #1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule